// File: doc/BRIEF.md
# Radio Configuration Register Bank

This block is the configuration and command register file of a radio module. An internal bus presents one transfer per cycle (write enable, read enable, address, write data and an address-phase flag). The bank holds a read-only identity word, a control word that can also be reached through a bit-set address and a bit-clear address, a command word whose bits become one-cycle trigger strobes, and an array of configuration words. Every writable word has a mask of implemented bits; the rest are reserved.

Burst access works without repeating the address. A transfer whose address-phase flag is high takes its address from the bus. A transfer with the flag low uses the address after the one used by the previous transfer. The address never advances past the last address of the window, so a long burst keeps hitting the top address and never wraps back to the identity or control words. Reading an address with no register behind it returns zero and latches an access-error flag. Writing 1 to command bit 0 puts the whole bank back into its reset state.

Top module: `radio_cfg_regbank`

## Requirements
- R1: After rst_n is released, ctrl_o equals CTRL_RST masked by CTRL_WMASK, config word i equals (CFG_RST_BASE + i) masked by CFG_WMASK, and cmd_o, acc_err and bus_rvalid are all 0.
- R2: The address map is: 0 identity, 1 control word, 2 control set alias, 3 control clear alias, 4 command word, 5 to 5+NCFG-1 config words, everything above up to 2**AW-1 unmapped. A write at address 1 loads the control word with wdata masked by CTRL_WMASK, a write at a config address loads that word with wdata masked by CFG_WMASK, and reads of addresses 1, 2 and 3 all return the control word.
- R3: A write at the set alias turns on the control bits that are 1 in wdata (within CTRL_WMASK) and leaves all other bits unchanged.
- R4: A write at the clear alias turns off the control bits that are 1 in wdata and leaves all other bits unchanged.
- R5: A write at the command address drives cmd_o with wdata[NCMD-1:0] during the following cycle only; cmd_o is 0 in every cycle that does not follow a command write. The command address reads as 0.
- R6: A command write with wdata bit 0 set returns the control word, the config words, the burst address and acc_err to their reset values in the next cycle.
- R7: A transfer with bus_first low uses the address of the previous transfer plus one; idle cycles do not move it.
- R8: The burst address stops at 2**AW-1: once a transfer has used that address, further transfers with bus_first low use it again.
- R9: The identity address always reads ID_VALUE; writes to it, to the command readback and to unmapped addresses change no stored register.
- R10: Bits outside CTRL_WMASK or CFG_WMASK ignore writes and read as 0.
- R11: A read returns its data on bus_rdata with bus_rvalid high in the cycle after the transfer; bus_rvalid is low after any cycle without a read and bus_rdata is then 0.
- R12: A read of an unmapped address returns 0 and sets acc_err, which stays set until reset or a soft reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Transfer address, used when bus_first is high |
| bus_wdata | input | DW | Write data |
| bus_wen | input | 1 | Write transfer this cycle |
| bus_ren | input | 1 | Read transfer this cycle |
| bus_first | input | 1 | Address phase present; low continues a burst |
| bus_rdata | output | DW | Read data, one cycle after the read |
| bus_rvalid | output | 1 | bus_rdata holds read data |
| ctrl_o | output | DW | Current control word |
| cfg_o | output | NCFG*DW | Config words, word i at bits i*DW upward |
| cmd_o | output | NCMD | One-cycle command strobes |
| acc_err | output | 1 | Sticky unmapped-read flag |

## Verification
Every result is due exactly one clock edge after the transfer that causes it: read data and its valid flag, the new control and config values, the command strobe, the error flag and the soft-reset return. The bench drives each transfer at a falling edge, lets one rising edge capture it and compares all outputs at the next falling edge, then expects the strobe to be gone one cycle later. Read data is predicted from the model state before the same transfer's write is applied, and the burst address model advances only on cycles that carry a transfer, so each expected value lines up with the single register stage between the bus and the outputs.

// File: rtl/rb_pkg.sv
package rb_pkg;

    localparam int unsigned OFF_ID   = 0;
    localparam int unsigned OFF_CTRL = 1;
    localparam int unsigned OFF_SET  = 2;
    localparam int unsigned OFF_CLR  = 3;
    localparam int unsigned OFF_CMD  = 4;
    localparam int unsigned OFF_CFG  = 5;

    typedef enum logic [2:0] {
        RGN_ID,
        RGN_CTRL,
        RGN_SET,
        RGN_CLR,
        RGN_CMD,
        RGN_CFG,
        RGN_NONE
    } region_e;

    function automatic region_e rb_decode(input int unsigned a, input int unsigned ncfg);
        region_e r;
        if (a == OFF_ID)                r = RGN_ID;
        else if (a == OFF_CTRL)         r = RGN_CTRL;
        else if (a == OFF_SET)          r = RGN_SET;
        else if (a == OFF_CLR)          r = RGN_CLR;
        else if (a == OFF_CMD)          r = RGN_CMD;
        else if (a < OFF_CFG + ncfg)    r = RGN_CFG;
        else                            r = RGN_NONE;
        return r;
    endfunction

endpackage

// File: rtl/rb_addr_seq.sv
module rb_addr_seq #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xfer,
    input  logic          first,
    input  logic [AW-1:0] addr_in,
    input  logic          sreset,
    output logic [AW-1:0] addr_eff
);
    localparam logic [AW-1:0] LAST = '1;

    typedef struct packed {
        logic [AW-1:0] ptr;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d    = seq_q;
        addr_eff = first ? addr_in : seq_q.ptr;
        if (xfer) begin
            seq_d.ptr = (addr_eff == LAST) ? LAST : addr_eff + 1'b1;
        end
        if (sreset) begin
            seq_d.ptr = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    // R8: a transfer at the top address leaves the pointer there
    a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !sreset && addr_eff == LAST) |=> (seq_q.ptr == LAST));

    // R7: a continuing transfer below the top advances by one
    a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !first && !sreset && seq_q.ptr != LAST) |=> (seq_q.ptr == $past(seq_q.ptr) + 1'b1));

    // R7: idle cycles hold the pointer
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer && !sreset) |=> $stable(seq_q.ptr));

endmodule

// File: rtl/rb_ctrl_word.sv
module rb_ctrl_word #(
    parameter int          DW    = 16,
    parameter logic [DW-1:0] RST   = '0,
    parameter logic [DW-1:0] WMASK = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_base,
    input  logic          wr_set,
    input  logic          wr_clr,
    input  logic [DW-1:0] wdata,
    input  logic          sreset,
    output logic [DW-1:0] ctrl
);
    localparam logic [DW-1:0] RST_M = RST & WMASK;

    typedef struct packed {
        logic [DW-1:0] word;
    } cw_t;

    cw_t cw_d, cw_q;

    always_comb begin
        cw_d = cw_q;
        if (wr_base) cw_d.word = wdata & WMASK;
        if (wr_set)  cw_d.word = cw_d.word | (wdata & WMASK);
        if (wr_clr)  cw_d.word = cw_d.word & ~wdata;
        if (sreset)  cw_d.word = RST_M;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cw_q.word <= RST_M;
        else        cw_q      <= cw_d;
    end

    assign ctrl = cw_q.word;

    // R3: set alias touches only the selected bits
    a_r3_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set && !wr_clr && !wr_base && !sreset) |=> (ctrl == ($past(ctrl) | ($past(wdata) & WMASK))));

    // R4: clear alias touches only the selected bits
    a_r4_clr_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && !wr_set && !wr_base && !sreset) |=> (ctrl == ($past(ctrl) & ~$past(wdata))));

    // R9: no write path active keeps the word
    a_r9_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_base && !wr_set && !wr_clr && !sreset) |=> $stable(ctrl));

    // R10: reserved bits stay zero
    a_r10_ctrl_resv: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl & ~WMASK) == '0);

endmodule

// File: rtl/rb_cfg_file.sv
module rb_cfg_file #(
    parameter int            DW       = 16,
    parameter int            NCFG     = 10,
    parameter int            IW       = 4,
    parameter logic [DW-1:0] RST_BASE = '0,
    parameter logic [DW-1:0] WMASK    = '1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IW-1:0]            idx,
    input  logic [DW-1:0]            wdata,
    input  logic                     sreset,
    output logic [NCFG-1:0][DW-1:0]  cfg
);
    typedef struct packed {
        logic [NCFG-1:0][DW-1:0] regs;
    } cf_t;

    cf_t cf_d, cf_q;
    logic [NCFG-1:0][DW-1:0] rst_vals;

    for (genvar g = 0; g < NCFG; g++) begin : g_rst
        assign rst_vals[g] = (RST_BASE + DW'(g)) & WMASK;

        // R10: reserved bits of each config word stay zero
        a_r10_cfg_resv: assert property (@(posedge clk) disable iff (!rst_n)
            (cf_q.regs[g] & ~WMASK) == '0);

        // R9: a word not addressed keeps its value
        a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!sreset && !(wr_en && int'(idx) == g)) |=> $stable(cf_q.regs[g]));
    end

    always_comb begin
        cf_d = cf_q;
        for (int i = 0; i < NCFG; i++) begin
            if (wr_en && int'(idx) == i) begin
                cf_d.regs[i] = wdata & WMASK;
            end
        end
        if (sreset) cf_d.regs = rst_vals;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cf_q.regs <= rst_vals;
        else        cf_q      <= cf_d;
    end

    assign cfg = cf_q.regs;

endmodule

// File: rtl/rb_cmd_strobe.sv
module rb_cmd_strobe #(
    parameter int NCMD = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [NCMD-1:0] wbits,
    output logic [NCMD-1:0] pulse
);
    typedef struct packed {
        logic [NCMD-1:0] bits;
    } cs_t;

    cs_t cs_d, cs_q;

    always_comb begin
        cs_d.bits = '0;
        if (wr) cs_d.bits = wbits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign pulse = cs_q.bits;

    // R5: a strobe lasts one cycle unless re-written
    a_r5_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse != '0 && !wr) |=> (pulse == '0));

    // R5: a command write shows up next cycle
    a_r5_strobe_out: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (pulse == $past(wbits)));

endmodule

// File: rtl/radio_cfg_regbank.sv
module radio_cfg_regbank
    import rb_pkg::*;
#(
    parameter int            AW           = 4,
    parameter int            DW           = 16,
    parameter int            NCFG         = 10,
    parameter int            NCMD         = 4,
    parameter logic [DW-1:0] ID_VALUE     = 16'hA51C,
    parameter logic [DW-1:0] CTRL_RST     = 16'h0005,
    parameter logic [DW-1:0] CTRL_WMASK   = 16'h3FFF,
    parameter logic [DW-1:0] CFG_RST_BASE = 16'h0100,
    parameter logic [DW-1:0] CFG_WMASK    = 16'h0FFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    input  logic               bus_wen,
    input  logic               bus_ren,
    input  logic               bus_first,
    output logic [DW-1:0]      bus_rdata,
    output logic               bus_rvalid,
    output logic [DW-1:0]      ctrl_o,
    output logic [NCFG*DW-1:0] cfg_o,
    output logic [NCMD-1:0]    cmd_o,
    output logic               acc_err
);
    localparam int IW = (NCFG > 1) ? $clog2(NCFG) : 1;

    typedef struct packed {
        logic [DW-1:0] rdata;
        logic          rvalid;
        logic          err;
    } top_t;

    top_t top_d, top_q;

    logic                    xfer;
    logic [AW-1:0]           addr_eff;
    region_e                 rgn;
    logic                    soft_rst;
    logic [IW-1:0]           cfg_idx;
    logic [NCFG-1:0][DW-1:0] cfg_w;

    assign xfer     = bus_wen | bus_ren;
    assign rgn      = rb_decode(int'(addr_eff), NCFG);
    assign soft_rst = bus_wen && (rgn == RGN_CMD) && bus_wdata[0];
    assign cfg_idx  = IW'(addr_eff - AW'(OFF_CFG));

    rb_addr_seq #(.AW(AW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .xfer     (xfer),
        .first    (bus_first),
        .addr_in  (bus_addr),
        .sreset   (soft_rst),
        .addr_eff (addr_eff)
    );

    rb_ctrl_word #(.DW(DW), .RST(CTRL_RST), .WMASK(CTRL_WMASK)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_base (bus_wen && rgn == RGN_CTRL),
        .wr_set  (bus_wen && rgn == RGN_SET),
        .wr_clr  (bus_wen && rgn == RGN_CLR),
        .wdata   (bus_wdata),
        .sreset  (soft_rst),
        .ctrl    (ctrl_o)
    );

    rb_cfg_file #(.DW(DW), .NCFG(NCFG), .IW(IW), .RST_BASE(CFG_RST_BASE), .WMASK(CFG_WMASK)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wen && rgn == RGN_CFG),
        .idx    (cfg_idx),
        .wdata  (bus_wdata),
        .sreset (soft_rst),
        .cfg    (cfg_w)
    );

    rb_cmd_strobe #(.NCMD(NCMD)) u_cmd (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wen && rgn == RGN_CMD),
        .wbits (bus_wdata[NCMD-1:0]),
        .pulse (cmd_o)
    );

    assign cfg_o = cfg_w;

    always_comb begin
        top_d        = top_q;
        top_d.rvalid = bus_ren;
        top_d.rdata  = '0;
        if (bus_ren) begin
            unique case (rgn)
                RGN_ID:                     top_d.rdata = ID_VALUE;
                RGN_CTRL, RGN_SET, RGN_CLR: top_d.rdata = ctrl_o;
                RGN_CFG:                    top_d.rdata = cfg_w[cfg_idx];
                RGN_CMD, RGN_NONE:          top_d.rdata = '0;
                default:                    top_d.rdata = '0;
            endcase
            if (rgn == RGN_NONE) top_d.err = 1'b1;
        end
        if (soft_rst) top_d.err = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign bus_rdata  = top_q.rdata;
    assign bus_rvalid = top_q.rvalid;
    assign acc_err    = top_q.err;

    // R11: valid follows a read by one cycle
    a_r11_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ren |=> bus_rvalid);

    // R11: no data without a read
    a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ren |=> (!bus_rvalid && bus_rdata == '0));

    // R12: error flag is sticky
    a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_err && !soft_rst) |=> acc_err);

    // R12: unmapped read yields zero
    a_r12_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ren && rgn == RGN_NONE) |=> (bus_rdata == '0 && acc_err));

    // R6: soft reset restores the control word and error flag
    a_r6_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (ctrl_o == (CTRL_RST & CTRL_WMASK) && !acc_err));

    // R9: identity read returns the fixed value
    a_r9_id_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ren && rgn == RGN_ID) |=> (bus_rdata == ID_VALUE));

endmodule

// File: tb/tb_radio_cfg_regbank.sv
module tb_radio_cfg_regbank;

    localparam int AW = 4;
    localparam int DW = 16;
    localparam int NCFG = 10;
    localparam int NCMD = 4;
    localparam logic [15:0] IDV   = 16'hA51C;
    localparam logic [15:0] CRST  = 16'h0005;
    localparam logic [15:0] CMSK  = 16'h3FFF;
    localparam logic [15:0] FBASE = 16'h0100;
    localparam logic [15:0] FMSK  = 16'h0FFF;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic               rst_n;
    logic [AW-1:0]      bus_addr;
    logic [DW-1:0]      bus_wdata;
    logic               bus_wen, bus_ren, bus_first;
    logic [DW-1:0]      bus_rdata;
    logic               bus_rvalid;
    logic [DW-1:0]      ctrl_o;
    logic [NCFG*DW-1:0] cfg_o;
    logic [NCMD-1:0]    cmd_o;
    logic               acc_err;

    radio_cfg_regbank dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wen(bus_wen), .bus_ren(bus_ren), .bus_first(bus_first),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .ctrl_o(ctrl_o),
        .cfg_o(cfg_o), .cmd_o(cmd_o), .acc_err(acc_err)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    logic [15:0] m_ctrl;
    logic [15:0] m_cfg [NCFG];
    bit          m_err;
    logic [3:0]  m_ptr;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ctrl = CRST & CMSK;
        for (int i = 0; i < NCFG; i++) m_cfg[i] = (FBASE + 16'(i)) & FMSK;
        m_err = 0;
        m_ptr = '0;
    endtask

    function automatic logic [15:0] model_read(input logic [3:0] a);
        if (a == 0) return IDV;
        if (a >= 1 && a <= 3) return m_ctrl;
        if (a >= 5 && a < 5 + NCFG) return m_cfg[a - 5];
        return 16'h0;
    endfunction

    task automatic check_state(input string tag);
        chk({tag, " ctrl_o"}, 32'(ctrl_o), 32'(m_ctrl));
        for (int i = 0; i < NCFG; i++) chk({tag, " cfg_o"}, 32'(cfg_o[i*DW +: DW]), 32'(m_cfg[i]));
        chk("R12 acc_err", 32'(acc_err), 32'(m_err));
    endtask

    task automatic do_xfer(input bit w, input bit r, input logic [3:0] a,
                           input logic [15:0] d, input bit first, input string tag);
        logic [3:0]  used;
        logic [15:0] exp_rd;
        logic [3:0]  exp_cmd;
        used    = first ? a : m_ptr;
        exp_rd  = r ? model_read(used) : 16'h0;
        exp_cmd = (w && used == 4) ? d[3:0] : 4'h0;
        bus_wen = w; bus_ren = r; bus_addr = a; bus_wdata = d; bus_first = first;
        @(posedge clk);
        @(negedge clk);
        bus_wen = 0; bus_ren = 0; bus_first = 0;
        if (w || r) m_ptr = (used == 4'hF) ? 4'hF : used + 4'h1;
        if (r && used >= 5 + NCFG) m_err = 1;
        if (w) begin
            case (used)
                4'd1: m_ctrl = d & CMSK;
                4'd2: m_ctrl = m_ctrl | (d & CMSK);
                4'd3: m_ctrl = m_ctrl & ~d;
                4'd4: if (d[0]) model_reset();
                default: if (used >= 5 && used < 5 + NCFG) m_cfg[used - 5] = d & FMSK;
            endcase
        end
        chk("R11 rvalid", 32'(bus_rvalid), 32'(r));
        chk({tag, " rdata"}, 32'(bus_rdata), 32'(exp_rd));
        chk("R5 cmd strobe", 32'(cmd_o), 32'(exp_cmd));
        check_state(tag);
    endtask

    function automatic string wtag(input logic [3:0] a);
        case (a)
            4'd0: return "R9 id write";
            4'd1: return "R10 ctrl masked";
            4'd2: return "R3 set alias";
            4'd3: return "R4 clr alias";
            4'd4: return "R6 cmd write";
            4'd15: return "R9 unmapped write";
            default: return "R2 cfg write";
        endcase
    endfunction

    function automatic string rtag(input logic [3:0] a);
        case (a)
            4'd0: return "R9 id read";
            4'd4: return "R5 cmd read";
            4'd15: return "R12 unmapped read";
            default: return "R2 map read";
        endcase
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] pats [5];
        pats[0] = 16'hFFFF; pats[1] = 16'h0000; pats[2] = 16'hA5A5;
        pats[3] = 16'h5A5A; pats[4] = 16'h1236;
        rst_n = 0; bus_addr = '0; bus_wdata = '0;
        bus_wen = 0; bus_ren = 0; bus_first = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        chk("R1 cmd_o", 32'(cmd_o), 0);
        chk("R1 rvalid", 32'(bus_rvalid), 0);
        check_state("R1 reset");

        // R2 R3 R4 R9 R10 R12: write every address with every pattern, read back all
        for (int p = 0; p < 5; p++) begin
            for (int a = 0; a < 16; a++) begin
                do_xfer(1, 0, 4'(a), pats[p], 1, wtag(4'(a)));
                for (int b = 0; b < 16; b++) do_xfer(0, 1, 4'(b), 16'h0, 1, rtag(4'(b)));
            end
        end

        // R5: command strobes without soft reset, then idle cycle clears them
        do_xfer(1, 0, 4'd4, 16'h000A, 1, "R5 cmd");
        do_xfer(0, 0, 4'd0, 16'h0, 1, "R5 idle");
        do_xfer(1, 0, 4'd4, 16'hFFF6, 1, "R5 cmd");
        do_xfer(1, 0, 4'd4, 16'h0004, 1, "R5 cmd back-to-back");
        do_xfer(0, 0, 4'd0, 16'h0, 1, "R5 idle");

        // R6: dirty state then soft reset
        do_xfer(1, 0, 4'd1, 16'h3C3C, 1, "R6 setup");
        do_xfer(1, 0, 4'd9, 16'h0777, 1, "R6 setup");
        do_xfer(0, 1, 4'd15, 16'h0, 1, "R12 set err");
        do_xfer(0, 1, 4'd1, 16'h0, 1, "R12 err sticky");
        do_xfer(1, 0, 4'd4, 16'h0001, 1, "R6 soft reset");
        do_xfer(0, 1, 4'd0, 16'h0, 0, "R6 ptr reset");

        // R7: write burst through config words, idle gap inside
        do_xfer(1, 0, 4'd5, 16'h1111, 1, "R7 burst wr");
        do_xfer(1, 0, 4'd0, 16'h2222, 0, "R7 burst wr");
        do_xfer(0, 0, 4'd0, 16'h0, 0, "R7 idle gap");
        do_xfer(1, 0, 4'd0, 16'h3333, 0, "R7 burst wr");
        do_xfer(0, 1, 4'd0, 16'h0, 1, "R7 burst rd");
        for (int k = 0; k < 17; k++) do_xfer(0, 1, 4'd0, 16'h0, 0, "R7 burst rd");

        // R8: burst past the top must not wrap into control word
        do_xfer(1, 0, 4'd1, 16'h0050, 1, "R8 setup");
        do_xfer(1, 0, 4'd13, 16'h0ABC, 1, "R8 burst wr");
        for (int k = 0; k < 4; k++) do_xfer(1, 0, 4'd0, 16'hFFFF, 0, "R8 no wrap");
        do_xfer(0, 1, 4'd12, 16'h0, 1, "R8 burst rd");
        for (int k = 0; k < 5; k++) do_xfer(0, 1, 4'd0, 16'h0, 0, "R8 saturate rd");

        // R3 R4: alias sequences on known values
        do_xfer(1, 0, 4'd1, 16'h00F0, 1, "R2 ctrl base");
        do_xfer(1, 0, 4'd2, 16'hC00F, 1, "R3 set alias");
        do_xfer(1, 0, 4'd3, 16'h0081, 1, "R4 clr alias");
        do_xfer(0, 1, 4'd3, 16'h0, 1, "R4 alias read");

        done = 1;
        summary();
        $finish;
    end

endmodule